// File: doc/BRIEF.md
# Input-Aware Approximate Multiply-Accumulate Unit

This block multiplies two unsigned 8-bit operands and adds the product into a 20-bit running sum. Each cycle it classifies both operands before forming the product, and sends the pair down one of three paths. A pair with a zero operand skips the arithmetic and contributes nothing. A pair where an operand is a power of two forms its product by shifting the other operand left. Every other pair goes through an ordinary 8x8 multiplier. The shift path replaces the multiplier for these pairs, which saves switching energy.

With approximation enabled, operands that lie within a small distance of a power of two are rounded to that power and also take the shift path. This gives an approximate product. Applications that tolerate some error, such as image filtering, accept this loss of accuracy in exchange for lower energy. With approximation disabled, every result is exact. A clear input starts a new accumulation. A registered path code reports which path produced the most recent product.

Top module: `approx_mac_unit`

## Requirements
- R1: When either operand of a valid pair is zero, the pair adds nothing to the sum and the path code becomes 0 (zero path).
- R2: When an operand is an exact power of two (1, 2, 4 ... 128), the product is the other operand shifted left by that operand's exponent. The result is exact and the path code becomes 1 (shift path).
- R3: With approxEn high, a nonzero operand that lies at most 2 away from its nearest power of two (2^0 to 2^8) is treated as that power. When two powers are equally near, the larger one is used. For example, 3 becomes 4, 6 becomes 8, 10 becomes 8, and 255 becomes 256. Such a pair uses the shift path (code 1).
- R4: With approxEn low, only exact powers of two use the shift path. Every other pair with two nonzero operands gives the exact product on the multiply path (code 2).
- R5: When both operands are shift candidates, the product is 1 shifted left by the sum of the two exponents. For example, 255 x 255 with approxEn high gives 65536.
- R6: Each cycle with inValid high adds exactly one product to the sum. Cycles with inValid low leave the sum unchanged, whatever the operands are.
- R7: clear high with inValid low sets the sum to 0 at the next edge. clear high with inValid high loads the sum with that pair's product alone.
- R8: The sum is 20 bits wide and wraps modulo 2^20.
- R9: outValid is high exactly in the cycle after a cycle with inValid high. pathCode changes only at those updates and holds its value otherwise. The value 3 never appears on pathCode.
- R10: While rstN is low, accOut, outValid and pathCode are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operand pair is valid this cycle |
| clear | input | 1 | Start a new accumulation (synchronous) |
| approxEn | input | 1 | Allow near-power-of-two rounding |
| opA | input | 8 | Unsigned operand A |
| opB | input | 8 | Unsigned operand B |
| accOut | output | 20 | Accumulated sum |
| outValid | output | 1 | Sum was updated at the last edge |
| pathCode | output | 2 | Path of latest product: 0 zero, 1 shift, 2 multiply |

## Verification
The bench tests each path on its own. Zero operands on either side exercise the zero path. Exact powers of two on side A, side B and both sides separate the three shift bases. Near-power values that tie, round down, round up to 256, or sit just outside the distance of 2 show whether the rounding rule is correct. The same operands are applied with approxEn both low and high, so an approximate result cannot pass as an exact one. A sweep of every value of opA against several fixed opB values, in both modes, compares each sum with a model that finds the nearest power by direct search. Runs of invalid cycles, clear with and without a pair, and a long chain of large products check the hold, restart and wraparound behaviour.

// File: rtl/approx_mac_pkg.sv
package approx_mac_pkg;

  // Width of the shift amount carried between control and datapath; large
  // enough for twice the exponent of any operand width this block supports.
  localparam int SHAMT_W = 8;

  typedef enum logic [1:0] {
    PATH_ZERO  = 2'd0,
    PATH_SHIFT = 2'd1,
    PATH_MULT  = 2'd2
  } pathSel_e;

  typedef enum logic [1:0] {
    BASE_A   = 2'd0,
    BASE_B   = 2'd1,
    BASE_ONE = 2'd2
  } shiftBase_e;

  typedef struct packed {
    logic               accLoad;
    logic               accClear;
    pathSel_e           path;
    shiftBase_e         base;
    logic [SHAMT_W-1:0] shiftAmt;
  } ctrlStrobes_t;

endpackage

// File: rtl/op_classifier.sv
module op_classifier #(
  parameter int OP_W     = 8,
  parameter int NEAR_TOL = 2,
  localparam int EXP_W   = $clog2(OP_W + 1)
) (
  input  logic [OP_W-1:0]  value,
  input  logic             approxEn,
  output logic             isZero,
  output logic             isCand,
  output logic [EXP_W-1:0] expOut
);

  logic [EXP_W-1:0] msbIdx;
  logic [OP_W:0]    floorPow;
  logic [OP_W:0]    distDown;
  logic [OP_W:0]    distUp;
  logic [OP_W:0]    nearDist;
  logic             takeUp;
  logic             isExact;
  logic             isNear;

  // Index of the highest set bit (0 when value is 0).
  always_comb begin
    msbIdx = '0;
    for (int i = 0; i < OP_W; i++) begin
      if (value[i]) msbIdx = EXP_W'(i);
    end
  end

  always_comb begin
    floorPow = (OP_W + 1)'(1) << msbIdx;
    distDown = {1'b0, value} - floorPow;
    distUp   = (floorPow << 1) - {1'b0, value};
    takeUp   = (distUp <= distDown);           // ties go to the larger power
    nearDist = takeUp ? distUp : distDown;
    isZero   = (value == '0);
    isExact  = !isZero && (distDown == '0);
    isNear   = !isZero && (nearDist <= (OP_W + 1)'(NEAR_TOL));
    isCand   = isExact || (approxEn && isNear);
    expOut   = (isExact || !takeUp) ? msbIdx : msbIdx + EXP_W'(1);
  end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import approx_mac_pkg::*;
#(
  parameter int OP_W     = 8,
  parameter int NEAR_TOL = 2
) (
  input  logic            inValid,
  input  logic            clear,
  input  logic            approxEn,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output ctrlStrobes_t    strobes
);

  localparam int EXP_W = $clog2(OP_W + 1);

  logic [1:0][OP_W-1:0]  opPair;
  logic [1:0]            zeroV;
  logic [1:0]            candV;
  logic [1:0][EXP_W-1:0] expV;

  assign opPair = {opB, opA};

  for (genvar g = 0; g < 2; g++) begin : g_class
    op_classifier #(
      .OP_W    (OP_W),
      .NEAR_TOL(NEAR_TOL)
    ) i_class (
      .value   (opPair[g]),
      .approxEn(approxEn),
      .isZero  (zeroV[g]),
      .isCand  (candV[g]),
      .expOut  (expV[g])
    );
  end

  always_comb begin
    strobes.accLoad  = inValid;
    strobes.accClear = clear;
    strobes.path     = PATH_MULT;
    strobes.base     = BASE_A;
    strobes.shiftAmt = '0;
    if (|zeroV) begin
      strobes.path = PATH_ZERO;
    end else if (candV[0] && candV[1]) begin
      strobes.path     = PATH_SHIFT;
      strobes.base     = BASE_ONE;
      strobes.shiftAmt = SHAMT_W'(expV[0]) + SHAMT_W'(expV[1]);
    end else if (candV[0]) begin
      strobes.path     = PATH_SHIFT;
      strobes.base     = BASE_B;
      strobes.shiftAmt = SHAMT_W'(expV[0]);
    end else if (candV[1]) begin
      strobes.path     = PATH_SHIFT;
      strobes.base     = BASE_A;
      strobes.shiftAmt = SHAMT_W'(expV[1]);
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import approx_mac_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  ctrlStrobes_t     strobes,
  output logic [ACC_W-1:0] accOut,
  output logic             outValid,
  output logic [1:0]       pathCode
);

  localparam int PROD_W = 2 * OP_W + 1;   // room for 2^(2*OP_W) from rounding

  logic [PROD_W-1:0] baseVal;
  logic [PROD_W-1:0] shiftVal;
  logic [PROD_W-1:0] mulVal;
  logic [PROD_W-1:0] product;
  logic [ACC_W-1:0]  accReg;
  logic [ACC_W-1:0]  accNext;
  logic              validReg;
  logic [1:0]        pathReg;

  always_comb begin
    unique case (strobes.base)
      BASE_A:   baseVal = PROD_W'(opA);
      BASE_B:   baseVal = PROD_W'(opB);
      default:  baseVal = PROD_W'(1);
    endcase
    shiftVal = baseVal << strobes.shiftAmt;
    mulVal   = PROD_W'(opA) * PROD_W'(opB);
    unique case (strobes.path)
      PATH_ZERO:  product = '0;
      PATH_SHIFT: product = shiftVal;
      default:    product = mulVal;
    endcase
  end

  always_comb begin
    accNext = accReg;
    if (strobes.accClear) begin
      accNext = strobes.accLoad ? ACC_W'(product) : '0;
    end else if (strobes.accLoad) begin
      accNext = accReg + ACC_W'(product);   // wraps modulo 2^ACC_W
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg   <= '0;
      validReg <= 1'b0;
      pathReg  <= 2'd0;
    end else begin
      accReg   <= accNext;
      validReg <= strobes.accLoad;
      if (strobes.accLoad) pathReg <= strobes.path;
    end
  end

  assign accOut   = accReg;
  assign outValid = validReg;
  assign pathCode = pathReg;

endmodule

// File: rtl/approx_mac_unit.sv
module approx_mac_unit
  import approx_mac_pkg::*;
#(
  parameter int OP_W     = 8,
  parameter int ACC_W    = 20,
  parameter int NEAR_TOL = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             clear,
  input  logic             approxEn,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [ACC_W-1:0] accOut,
  output logic             outValid,
  output logic [1:0]       pathCode
);

  ctrlStrobes_t strobes;

  mac_ctrl #(
    .OP_W    (OP_W),
    .NEAR_TOL(NEAR_TOL)
  ) i_ctrl (
    .inValid (inValid),
    .clear   (clear),
    .approxEn(approxEn),
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes)
  );

  mac_datapath #(
    .OP_W (OP_W),
    .ACC_W(ACC_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .accOut  (accOut),
    .outValid(outValid),
    .pathCode(pathCode)
  );

endmodule

// File: rtl/approx_mac_checker.sv
module approx_mac_checker #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             clear,
  input logic             approxEn,
  input logic [OP_W-1:0]  opA,
  input logic [OP_W-1:0]  opB,
  input logic [ACC_W-1:0] accOut,
  input logic             outValid,
  input logic [1:0]       pathCode
);

  // R1: a zero operand routes to the zero path and leaves the sum as it was
  assert_zero_forward_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !clear && (opA == '0 || opB == '0))
      |=> (pathCode == 2'd0 && accOut == $past(accOut)));

  // R2: exact power of two on a nonzero pair takes the shift path
  assert_exact_pow_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opA != '0 && opB != '0 &&
     ($countones(opA) == 1 || $countones(opB) == 1)) |=> (pathCode == 2'd1));

  // R4: with rounding off, a pair of non-powers uses the multiplier
  assert_exact_mode_mult_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !approxEn && opA != '0 && opB != '0 &&
     $countones(opA) != 1 && $countones(opB) != 1) |=> (pathCode == 2'd2));

  // R6: no valid pair and no clear holds the sum
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !clear) |=> $stable(accOut));

  // R7: clear alone empties the sum
  assert_clear_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clear && !inValid) |=> (accOut == '0));

  // R9: output valid follows input valid by one cycle
  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(pathCode)));
  assert_path_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    pathCode != 2'd3);

  // R10: reset values
  always_comb begin
    if (!rstN) begin
      assert_reset_state_R10: assert (accOut == '0 && !outValid && pathCode == 2'd0);
    end
  end

endmodule

bind approx_mac_unit approx_mac_checker #(
  .OP_W (OP_W),
  .ACC_W(ACC_W)
) i_checker (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .clear   (clear),
  .approxEn(approxEn),
  .opA     (opA),
  .opB     (opB),
  .accOut  (accOut),
  .outValid(outValid),
  .pathCode(pathCode)
);

// File: tb/test_approx_mac_unit.sv
`timescale 1ns/1ps
module test_approx_mac_unit;

  localparam int OP_W  = 8;
  localparam int ACC_W = 20;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             clear = 1'b0;
  logic             approxEn = 1'b0;
  logic [OP_W-1:0]  opA = '0;
  logic [OP_W-1:0]  opB = '0;
  logic [ACC_W-1:0] accOut;
  logic             outValid;
  logic [1:0]       pathCode;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;
  int modelAcc = 0;
  int modelPath = 0;

  always #2 clk = ~clk;   // 250 MHz

  approx_mac_unit #(.OP_W(OP_W), .ACC_W(ACC_W)) i_approx_mac_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .clear(clear),
    .approxEn(approxEn), .opA(opA), .opB(opB),
    .accOut(accOut), .outValid(outValid), .pathCode(pathCode)
  );

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 200000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycleCount);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Nearest power by direct search; ties favour the larger exponent.
  task automatic refClass(input int v, input bit en, output bit cand, output int e);
    int bestD;
    bestD = 1 << 30;
    e = 0;
    for (int k = 0; k <= 8; k++) begin
      int d;
      d = (v > (1 << k)) ? v - (1 << k) : (1 << k) - v;
      if (d <= bestD) begin bestD = d; e = k; end
    end
    cand = (v != 0) && (bestD == 0 || (en && bestD <= 2));
  endtask

  task automatic refProduct(input int a, input int b, input bit en,
                            output int prod, output int path);
    bit ca, cb;
    int ea, eb;
    refClass(a, en, ca, ea);
    refClass(b, en, cb, eb);
    if (a == 0 || b == 0) begin prod = 0; path = 0; end
    else if (ca && cb) begin prod = 1 << (ea + eb); path = 1; end
    else if (ca) begin prod = b << ea; path = 1; end
    else if (cb) begin prod = a << eb; path = 1; end
    else begin prod = a * b; path = 2; end
  endtask

  // Drive one cycle from a falling edge; return at the next falling edge.
  task automatic drive(input bit v, input int a, input int b, input bit en, input bit clr);
    inValid = v; opA = OP_W'(a); opB = OP_W'(b); approxEn = en; clear = clr;
    @(negedge clk);
    inValid = 1'b0; clear = 1'b0;
  endtask

  task automatic pairCheck(input string req, input int a, input int b,
                           input bit en, input bit clr);
    int p, path;
    refProduct(a, b, en, p, path);
    drive(1'b1, a, b, en, clr);
    modelAcc  = (clr ? p : modelAcc + p) & ((1 << ACC_W) - 1);
    modelPath = path;
    check({req, " sum"},   int'(accOut),   modelAcc);
    check({req, " path"},  int'(pathCode), modelPath);
    check({req, " valid"}, int'(outValid), 1);
  endtask

  task automatic testReset();
    check("R10 acc",   int'(accOut),   0);
    check("R10 valid", int'(outValid), 0);
    check("R10 path",  int'(pathCode), 0);
  endtask

  task automatic testZero();
    pairCheck("R7 start", 7, 9, 1'b0, 1'b1);
    pairCheck("R1 zeroA", 0, 200, 1'b1, 1'b0);
    check("R1 zeroA held", int'(accOut), 63);
    pairCheck("R1 zeroB", 128, 0, 1'b0, 1'b0);
    check("R1 zeroB path", int'(pathCode), 0);
  endtask

  task automatic testExactPow();
    pairCheck("R2 powA", 16, 13, 1'b0, 1'b1);
    check("R2 powA value", int'(accOut), 208);
    pairCheck("R2 powB", 201, 1, 1'b0, 1'b1);
    check("R2 powB value", int'(accOut), 201);
    pairCheck("R2 pow128", 128, 99, 1'b1, 1'b1);
    check("R2 pow128 value", int'(accOut), 12672);
  endtask

  task automatic testApproxOn();
    pairCheck("R3 tie3", 3, 11, 1'b1, 1'b1);     // 3 -> 4, 11 not near
    check("R3 tie3 value", int'(accOut), 44);
    pairCheck("R3 tie6", 6, 13, 1'b1, 1'b1);     // 6 -> 8
    check("R3 tie6 value", int'(accOut), 104);
    pairCheck("R3 down10", 13, 10, 1'b1, 1'b1);  // 10 -> 8
    check("R3 down10 value", int'(accOut), 104);
    pairCheck("R3 outside12", 12, 11, 1'b1, 1'b1);  // 12 is 4 from both
    check("R3 outside12 path", int'(pathCode), 2);
    check("R3 outside12 value", int'(accOut), 132);
    pairCheck("R3 up256", 254, 11, 1'b1, 1'b1);  // 254 -> 256
    check("R3 up256 value", int'(accOut), 2816);
  endtask

  task automatic testApproxOff();
    pairCheck("R4 exact3", 3, 11, 1'b0, 1'b1);
    check("R4 exact3 path", int'(pathCode), 2);
    check("R4 exact3 value", int'(accOut), 33);
    pairCheck("R4 exact255", 255, 254, 1'b0, 1'b1);
    check("R4 exact255 value", int'(accOut), 64770);
  endtask

  task automatic testBothPow();
    pairCheck("R5 exact", 128, 64, 1'b0, 1'b1);
    check("R5 exact value", int'(accOut), 8192);
    pairCheck("R5 approx", 255, 255, 1'b1, 1'b1);
    check("R5 approx value", int'(accOut), 65536);
    pairCheck("R5 mixed", 7, 9, 1'b1, 1'b1);     // 8 * 8
    check("R5 mixed value", int'(accOut), 64);
  endtask

  task automatic testHold();
    pairCheck("R6 seed", 21, 5, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 37 + i, 91, 1'b1, 1'b0);
      check("R6 idle sum", int'(accOut), modelAcc);
      check("R9 idle valid", int'(outValid), 0);
      check("R9 idle path held", int'(pathCode), modelPath);
    end
    pairCheck("R6 once", 3, 3, 1'b0, 1'b0);
  endtask

  task automatic testClear();
    pairCheck("R7 seed", 100, 100, 1'b0, 1'b1);
    drive(1'b0, 55, 55, 1'b0, 1'b1);
    modelAcc = 0;
    check("R7 clear alone", int'(accOut), 0);
    check("R9 clear no valid", int'(outValid), 0);
    pairCheck("R7 clear load", 9, 9, 1'b0, 1'b0);
    pairCheck("R7 clear with pair", 5, 7, 1'b0, 1'b1);
    check("R7 load value", int'(accOut), 35);
  endtask

  task automatic testWrap();
    pairCheck("R8 start", 255, 255, 1'b0, 1'b1);
    for (int i = 0; i < 16; i++) pairCheck("R8 chain", 255, 255, 1'b0, 1'b0);
    check("R8 wrapped value", int'(accOut), (17 * 65025) % (1 << 20));
  endtask

  task automatic testSweep();
    int bList[4] = '{3, 77, 128, 200};
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < 4; j++) begin
        pairCheck("R3 R4 sweep start", 0, 0, bit'(m), 1'b1);
        for (int a = 0; a < 256; a++) pairCheck("R3 R4 sweep", a, bList[j], bit'(m), 1'b0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testZero();
    testExactPow();
    testApproxOn();
    testApproxOff();
    testBothPow();
    testHold();
    testClear();
    testWrap();
    testSweep();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule